// File: doc/BRIEF.md
# Leading-One Predictor for Wide Operand Addition

This block guesses where the leading significant digit of `a + b` will land, and it does so from the two addends alone, so the guess is ready at about the same time as the carry-propagate sum it goes with. It runs beside the adder of a floating-point datapath. Its answer drives the normalization left shifter, so the shift amount does not wait for the sum.

Each bit column is sorted into one of three classes from its two operand bits: the bits differ, both bits are one, or both bits are zero. A short window of neighbouring classes then sets a one-bit flag per column. The most significant set flag is the predicted position. A pairwise binary tree turns the flag string into a shift count and a valid bit. The carry that enters from the right is never consulted, so the count can be one less than the true leading-zero count of the sum. A later correction stage, outside this block, absorbs that single-bit slip.

The operand width is a parameter. Widths that are not a power of two are padded on the right for the tree. Results are registered once.

Top module: `lza_anticipator`

## Requirements
- R1: For a column j that is neither the top nor the bottom column, let t = a XOR b, g = a AND b and z = NOR(a, b), each taken per column. The flag hint[j] is then (g[j]&~z[j-1] | z[j]&~g[j-1]) when t[j+1]=1, and (z[j]&~z[j-1] | g[j]&~g[j-1]) when t[j+1]=0.
- R2: The top flag hint[WIDTH-1] equals ~t[WIDTH-1] & t[WIDTH-2].
- R3: Column 0 uses the R1 rule with a virtual column below it whose operand bits are both zero (z=1, g=0).
- R4: When hint is non-zero, shift_vld is 1 and shift_cnt is the number of zeros above the highest set bit of hint, counted from bit WIDTH-1.
- R5: When hint is all zeros, shift_vld is 0, and shift_cnt then carries no meaning.
- R6: Read a and b as two's complement numbers whose sum fits in WIDTH bits. If that sum is positive, shift_vld is 1 and shift_cnt equals either its leading-zero count or that count minus one.
- R7: Under the same reading, a sum of exactly zero gives shift_vld = 0.
- R8: The outputs reflect the operands presented one clock earlier. While rst_n is low, every output reads zero.
- R9: A width that is not a power of two gives the same results as R1 to R7. The tree is padded with zero flags below column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | WIDTH | First addend |
| opnd_b | input | WIDTH | Second addend |
| hint_q | output | WIDTH | Registered per-column flag string |
| shift_cnt_q | output | $clog2(pad width) | Registered predicted leading-zero count |
| shift_vld_q | output | 1 | Registered flag: some column flag is set |

## Verification
Every operand pair of an 8-bit instance is applied, and the 6-bit instance sees every pair of its own width. This exercises each column-class window at the top, the interior and the bottom edge, and separates faults in the flag equations from faults in the count tree.

Pairs whose sum is positive test the one-bit prediction window. They show whether a slip ever goes past one bit or points the wrong way. Pairs that cancel to zero test that nothing spurious is flagged. The odd width shows whether the padding disturbs the count.

// File: rtl/lza_pkg.sv
package lza_pkg;

    // Classification of one bit column of the two addends.
    typedef struct packed {
        logic t;   // operand bits differ
        logic g;   // both bits one
        logic z;   // both bits zero
    } lza_col_t;

    // Smallest power of two, at least 2, that holds w flags.
    function automatic int lza_pad_width(input int w);
        int p;
        p = 2;
        while (p < w) p = p * 2;
        return p;
    endfunction

endpackage

// File: rtl/lza_indicator.sv
module lza_indicator
    import lza_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] ind_o
);

    lza_col_t [W-1:0] cls;

    generate
        for (genvar j = 0; j < W; j++) begin : g_col
            assign cls[j].t = a_i[j] ^ b_i[j];
            assign cls[j].g = a_i[j] & b_i[j];
            assign cls[j].z = ~a_i[j] & ~b_i[j];

            if (j == W - 1) begin : g_top
                // top column looks only at its own and the next difference bit
                assign ind_o[j] = ~cls[j].t & cls[j-1].t;
            end else begin : g_body
                logic nz;
                logic ng;
                if (j == 0) begin : g_pad
                    // virtual column below the LSB: both operand bits zero
                    assign nz = 1'b1;
                    assign ng = 1'b0;
                end else begin : g_nbr
                    assign nz = cls[j-1].z;
                    assign ng = cls[j-1].g;
                end
                assign ind_o[j] = cls[j+1].t
                    ? ((cls[j].g & ~nz) | (cls[j].z & ~ng))
                    : ((cls[j].z & ~nz) | (cls[j].g & ~ng));
            end
        end
    endgenerate

endmodule

// File: rtl/lza_lzd_merge.sv
module lza_lzd_merge #(
    parameter int PW = 1
) (
    input  logic          hi_any,
    input  logic [PW-1:0] hi_pos,
    input  logic          lo_any,
    input  logic [PW-1:0] lo_pos,
    output logic          any_o,
    output logic [PW:0]   pos_o
);

    // Upper half wins whenever it holds a one; otherwise the lower half's
    // offset is taken with the new position MSB set.
    assign any_o = hi_any | lo_any;
    assign pos_o = hi_any ? {1'b0, hi_pos} : {1'b1, lo_pos};

endmodule

// File: rtl/lza_lzd_tree.sv
module lza_lzd_tree #(
    parameter  int W  = 64,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [PW-1:0] pos_o
);

    generate
        if (W == 2) begin : g_leaf
            assign any_o = vec_i[1] | vec_i[0];
            assign pos_o = ~vec_i[1];
        end else begin : g_split
            localparam int HW = W / 2;
            logic          hi_any;
            logic          lo_any;
            logic [PW-2:0] hi_pos;
            logic [PW-2:0] lo_pos;

            lza_lzd_tree #(.W(HW)) u_hi (
                .vec_i (vec_i[W-1:HW]),
                .any_o (hi_any),
                .pos_o (hi_pos)
            );

            lza_lzd_tree #(.W(HW)) u_lo (
                .vec_i (vec_i[HW-1:0]),
                .any_o (lo_any),
                .pos_o (lo_pos)
            );

            lza_lzd_merge #(.PW(PW - 1)) u_mrg (
                .hi_any (hi_any),
                .hi_pos (hi_pos),
                .lo_any (lo_any),
                .lo_pos (lo_pos),
                .any_o  (any_o),
                .pos_o  (pos_o)
            );
        end
    endgenerate

endmodule

// File: rtl/lza_anticipator.sv
module lza_anticipator
    import lza_pkg::*;
#(
    parameter  int WIDTH = 64,
    localparam int PAD_W = lza_pad_width(WIDTH),
    localparam int CNT_W = $clog2(PAD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] hint_q,
    output logic [CNT_W-1:0] shift_cnt_q,
    output logic             shift_vld_q
);

    typedef struct packed {
        logic [WIDTH-1:0] hint;
        logic [CNT_W-1:0] cnt;
        logic             vld;
    } lza_state_t;

    lza_state_t       st_d;
    lza_state_t       st_q;
    logic [WIDTH-1:0] ind_w;
    logic [PAD_W-1:0] pad_w;
    logic             any_w;
    logic [CNT_W-1:0] pos_w;

    lza_indicator #(.W(WIDTH)) u_ind (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .ind_o (ind_w)
    );

    generate
        if (PAD_W == WIDTH) begin : g_nopad
            assign pad_w = ind_w;
        end else begin : g_pad
            assign pad_w = {ind_w, {(PAD_W - WIDTH){1'b0}}};
        end
    endgenerate

    lza_lzd_tree #(.W(PAD_W)) u_tree (
        .vec_i (pad_w),
        .any_o (any_w),
        .pos_o (pos_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.hint = ind_w;
        st_d.cnt  = pos_w;
        st_d.vld  = any_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hint_q      = st_q.hint;
    assign shift_cnt_q = st_q.cnt;
    assign shift_vld_q = st_q.vld;

    AST_VLD_TRACKS_HINT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_vld_q == (|hint_q));  // R5
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_vld_q |-> (int'(shift_cnt_q) < WIDTH));  // R4
    AST_CNT_HITS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_vld_q |-> hint_q[WIDTH - 1 - int'(shift_cnt_q)]);  // R4
    AST_NOTHING_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_vld_q |-> ((hint_q >> (WIDTH - int'(shift_cnt_q))) == '0));  // R4
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!shift_vld_q && hint_q == '0 && shift_cnt_q == '0));  // R8

endmodule

// File: tb/lza_anticipator_bench.sv
module lza_anticipator_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a8 = '0, b8 = '0;
    logic [5:0] a6 = '0, b6 = '0;
    logic [7:0] hint8;
    logic [5:0] hint6;
    logic [2:0] cnt8, cnt6;
    logic       vld8, vld6;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    lza_anticipator #(.WIDTH(8)) u_lza_anticipator (
        .clk(clk), .rst_n(rst_n), .opnd_a(a8), .opnd_b(b8),
        .hint_q(hint8), .shift_cnt_q(cnt8), .shift_vld_q(vld8));

    lza_anticipator #(.WIDTH(6)) u_lza_anticipator_w6 (
        .clk(clk), .rst_n(rst_n), .opnd_a(a6), .opnd_b(b6),
        .hint_q(hint6), .shift_cnt_q(cnt6), .shift_vld_q(vld6));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Flag string from the column rules (R1, R2, R3).
    function automatic logic [7:0] ref_flags(input logic [7:0] a, input logic [7:0] b, input int w);
        logic [7:0] t, g, z, f;
        logic nz, ng;
        t = a ^ b; g = a & b; z = ~a & ~b; f = '0;
        for (int j = 0; j < w; j++) begin
            if (j == w - 1) begin
                f[j] = ~t[j] & t[j-1];
            end else begin
                nz = (j == 0) ? 1'b1 : z[j-1];
                ng = (j == 0) ? 1'b0 : g[j-1];
                f[j] = t[j+1] ? ((g[j] & ~nz) | (z[j] & ~ng))
                              : ((z[j] & ~nz) | (g[j] & ~ng));
            end
        end
        return f;
    endfunction

    function automatic int lead_zeros(input logic [7:0] v, input int w);
        for (int j = w - 1; j >= 0; j--) if (v[j]) return w - 1 - j;
        return w;
    endfunction

    function automatic int as_signed(input int v, input int w);
        int m;
        m = v % (1 << w);
        return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
    endfunction

    task automatic check_pair(input int ai, input int bi, input int w,
                              input logic [7:0] hint, input logic [2:0] cnt, input logic vld);
        logic [7:0] exp;
        logic [7:0] sv;
        int s, lz;
        string tag;
        tag = (w == 6) ? "R9 " : "";
        exp = ref_flags(ai[7:0], bi[7:0], w);
        check(hint[w-1] == exp[w-1], {tag, "R2 top flag"}, int'(hint[w-1]), int'(exp[w-1]));
        check(hint[0] == exp[0], {tag, "R3 bottom flag"}, int'(hint[0]), int'(exp[0]));
        check(hint == exp, {tag, "R1 flag string"}, int'(hint), int'(exp));
        if (exp != 0) begin
            check(vld && int'(cnt) == lead_zeros(exp, w), {tag, "R4 count of flags"},
                  int'(cnt), lead_zeros(exp, w));
        end else begin
            check(!vld, {tag, "R5 empty flags"}, int'(vld), 0);
        end
        s = as_signed(ai, w) + as_signed(bi, w);
        if (s >= -(1 << (w - 1)) && s < (1 << (w - 1))) begin
            if (s > 0) begin
                sv = 8'(s);
                lz = lead_zeros(sv, w);
                check(vld && (int'(cnt) == lz || int'(cnt) == lz - 1),
                      {tag, "R6 prediction window"}, int'(cnt), lz);
            end else if (s == 0) begin
                check(!vld, {tag, "R7 cancelled sum"}, int'(vld), 0);
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (!done && cycles > 190000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog R8 actual=%0d expected=%0d", cycles, 190000);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        // R8: reset holds all outputs at zero with live operands
        a8 = 8'h41; b8 = 8'h02; a6 = 6'h11; b6 = 6'h02;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(hint8 == 0 && cnt8 == 0 && !vld8, "R8 reset state", int'(hint8), 0);
        check(hint6 == 0 && cnt6 == 0 && !vld6, "R8 reset state w6", int'(hint6), 0);
        rst_n = 1'b1;

        // R8: outputs follow operands after exactly one rising edge
        @(negedge clk);
        a8 = 8'h01; b8 = 8'h00; a6 = 6'h01; b6 = 6'h00;
        @(negedge clk);
        check(vld8 && cnt8 == 3'd6, "R8 one-cycle latency", int'(cnt8), 6);

        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                a8 = ai[7:0]; b8 = bi[7:0];
                a6 = ai[5:0]; b6 = bi[5:0];
                @(negedge clk);
                check_pair(ai, bi, 8, hint8, cnt8, vld8);
                if (ai < 64 && bi < 64)
                    check_pair(ai, bi, 6, {2'b00, hint6}, cnt6, vld6);
            end
        end

        // R8: a second reset clears a non-zero result
        a8 = 8'h10; b8 = 8'h00;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(hint8 == 0 && cnt8 == 0 && !vld8, "R8 reset clears", int'(hint8), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule